// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end of a cache maintenance engine that several CPUs share. Each CPU posts invalidate, clean or flush commands through one small register window. The shared command registers hold the mode, the start address and the byte size. An ownership lock keeps one CPU's write sequence atomic. Registration and completion status are kept separately for every CPU, so each CPU follows only the commands it posted itself.

An accepted command goes into a FIFO. A line-walking executor takes commands from the FIFO one at a time and emits one line strobe per cycle. A command covers either a byte range, with the start rounded down to a line boundary, or every set of the cache. Software can also request a sync, which reports busy until every queued and running command has drained, and a prefetch-buffer flush, which becomes a one-cycle pulse.

The usual software sequence is: write the mode, write the address, write the size, then read the registration status. If the status is non-zero, the whole sequence is repeated. After a command that asked for notification, software polls the queue status until the done flag is set.

Top module: `cmq_top`

## Requirements
- R1: After reset, the registration status (0x25C), the queue status (0x260) and the primitive register (0x244) read 0 for every CPU, and no line strobe is emitted.
- R2: The first CPU to write the mode register (0x248) while the lock is free becomes the lock owner. A mode write from any other CPU while the lock is held sets bit 0 of that CPU's own registration status. Address (0x24C) and size (0x250) writes from a non-owner have no effect on the command that the owner posts.
- R3: A read of 0x25C by the lock owner enqueues the shared command, returns 0 when the queue had room, and releases the lock, so another CPU can then take it.
- R4: When the queue holds its full depth of entries, an owner read of 0x25C returns 2 (bit 1 set), enqueues nothing and releases the lock.
- R5: A command with scope field bits 18:17 equal to 0 is a range command. It emits one line strobe per line, from the start address rounded down to a line boundary up to but excluding start+size. Every strobe carries line_cmd equal to mode bits 1:0 (0 invalidate, 1 clean, 2 flush).
- R6: A command with scope field 1 ignores the address and size and emits a strobe for each set index k, at address k*LINE_BYTES.
- R7: Commands execute strictly one after another, in the order they were accepted, whatever CPUs posted them.
- R8: When a command finishes, bit 2 of the posting CPU's queue status is set only if mode bit 15 was set; no other CPU's flag changes. Writing a word with bit 2 set to 0x260 clears the writing CPU's flag.
- R9: Bit 0 of a CPU's queue status is 1 while at least one of that CPU's commands waits in the queue. Bit 1 is 1 while the executor runs one of that CPU's commands.
- R10: Writing 8 to 0x244 starts a sync. Reads of 0x244 return 1 until the queue is empty and the executor is idle, and 0 after that.
- R11: Writing 9 to 0x244 raises pf_flush for exactly one cycle, in the cycle after the write.
- R12: A read of 0x25C by a CPU that does not hold the lock returns that CPU's stored registration result and leaves the lock with its owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| req_cpu | input | CPU_W | ID of the accessing CPU |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| line_valid | output | 1 | One maintenance line strobe |
| line_addr | output | 32 | Line-aligned address of the strobe |
| line_cmd | output | 2 | Command of the strobe |
| pf_flush | output | 1 | Prefetch-buffer flush pulse |

## Verification
The bench builds the block with 4 CPUs, a queue depth of 4, 8 sets and 16-byte lines. The short whole-cache walk keeps the scoreboard small. The shallow queue is filled by five 64-line range posts before the sixth is refused, so the full case comes within a few dozen cycles. Those long walks also leave a wide window in which other CPUs' queued and running status bits, the lock conflict results and a pending sync can each be observed while the executor is busy.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

  localparam logic [11:0] OFS_PRIM    = 12'h244;
  localparam logic [11:0] OFS_MODE    = 12'h248;
  localparam logic [11:0] OFS_ADDR    = 12'h24C;
  localparam logic [11:0] OFS_SIZE    = 12'h250;
  localparam logic [11:0] OFS_REGSTAT = 12'h25C;
  localparam logic [11:0] OFS_QSTAT   = 12'h260;

  localparam logic [31:0] PRIM_SYNC   = 32'h8;
  localparam logic [31:0] PRIM_PFLUSH = 32'h9;

  typedef struct packed {
    logic [1:0]  cmd;
    logic        whole;
    logic        notify;
    logic [31:0] addr;
    logic [31:0] size;
  } cmq_entry_t;

  localparam int ENTRY_W = $bits(cmq_entry_t);

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
  parameter int DATA_W  = 8,
  parameter int Q_DEPTH = 8,
  parameter int CNT_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(Q_DEPTH - 1);

  logic [DATA_W-1:0] mem [Q_DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  assign full      = (count == CNT_W'(Q_DEPTH));
  assign empty     = (count == '0);
  assign head_data = mem[rptr];

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push && !full) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop && !empty) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(push && !full) - CNT_W'(pop && !empty);
    end
  end
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
  import cmq_pkg::*;
#(
  parameter int N_SETS     = 64,
  parameter int LINE_BYTES = 32,
  parameter int CPU_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_empty,
  input  cmq_entry_t       head,
  input  logic [CPU_W-1:0] head_cpu,
  output logic             pop,
  output logic             busy,
  output logic [CPU_W-1:0] cur_cpu,
  output logic             done_valid,
  output logic [CPU_W-1:0] done_cpu,
  output logic             done_notify,
  output logic             line_valid,
  output logic [31:0]      line_addr,
  output logic [1:0]       line_cmd
);
  localparam int LOG2L = $clog2(LINE_BYTES);
  localparam int REM_W = 34;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FIN} exec_st_t;

  exec_st_t          st;
  logic [31:0]       cur_addr;
  logic [REM_W-1:0]  remain;
  logic [1:0]        cmd_q;
  logic              notify_q;

  logic [REM_W-1:0]  span;
  logic [REM_W-1:0]  n_lines;
  logic [31:0]       first_line;

  always_comb begin
    span       = REM_W'(head.addr[LOG2L-1:0]) + REM_W'(head.size) + REM_W'(LINE_BYTES - 1);
    n_lines    = head.whole ? REM_W'(N_SETS) : (span >> LOG2L);
    first_line = head.whole ? 32'd0 : {head.addr[31:LOG2L], {LOG2L{1'b0}}};
  end

  assign pop         = (st == ST_IDLE) && !q_empty;
  assign busy        = (st != ST_IDLE);
  assign done_valid  = (st == ST_FIN);
  assign done_cpu    = cur_cpu;
  assign done_notify = notify_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      cmd_q      <= '0;
      notify_q   <= 1'b0;
      cur_cpu    <= '0;
      line_valid <= 1'b0;
      line_addr  <= '0;
      line_cmd   <= '0;
    end else begin
      line_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!q_empty) begin
            cur_addr <= first_line;
            remain   <= n_lines;
            cmd_q    <= head.cmd;
            notify_q <= head.notify;
            cur_cpu  <= head_cpu;
            st       <= (n_lines == '0) ? ST_FIN : ST_WALK;
          end
        end
        ST_WALK: begin
          line_valid <= 1'b1;
          line_addr  <= cur_addr;
          line_cmd   <= cmd_q;
          cur_addr   <= cur_addr + 32'(LINE_BYTES);
          remain     <= remain - 1'b1;
          if (remain == REM_W'(1)) st <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmq_regs.sv
module cmq_regs
  import cmq_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int CPU_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [CPU_W-1:0] req_cpu,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             push,
  output cmq_entry_t       push_entry,
  output logic [CPU_W-1:0] push_cpu,
  input  logic             q_full,
  input  logic             q_empty,
  input  logic             pop,
  input  logic [CPU_W-1:0] pop_cpu,
  input  logic             exec_busy,
  input  logic [CPU_W-1:0] exec_cpu,
  input  logic             done_valid,
  input  logic [CPU_W-1:0] done_cpu,
  input  logic             done_notify,
  output logic             lock_valid,
  output logic [CPU_W-1:0] lock_owner,
  output logic             sync_pend,
  output logic [N_CPU-1:0] done_flags,
  output logic             pf_flush
);
  cmq_entry_t shr_q;

  logic acc_wr, acc_rd, is_owner, mode_wr, take, clash, commit, sync_wr, pf_wr;
  assign acc_wr   = req_valid && req_write;
  assign acc_rd   = req_valid && !req_write;
  assign is_owner = lock_valid && (lock_owner == req_cpu);
  assign mode_wr  = acc_wr && (req_addr == OFS_MODE);
  assign take     = mode_wr && (!lock_valid || lock_owner == req_cpu);
  assign clash    = mode_wr && !take;
  assign commit   = acc_rd && (req_addr == OFS_REGSTAT) && is_owner;
  assign sync_wr  = acc_wr && (req_addr == OFS_PRIM) && (req_wdata == PRIM_SYNC);
  assign pf_wr    = acc_wr && (req_addr == OFS_PRIM) && (req_wdata == PRIM_PFLUSH);

  assign push       = commit && !q_full;
  assign push_entry = shr_q;
  assign push_cpu   = req_cpu;

  // lock and shared command registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_valid <= 1'b0;
      lock_owner <= '0;
      shr_q      <= '0;
    end else begin
      if (take) begin
        lock_valid   <= 1'b1;
        lock_owner   <= req_cpu;
        shr_q.cmd    <= req_wdata[1:0];
        shr_q.whole  <= (req_wdata[18:17] == 2'd1);
        shr_q.notify <= req_wdata[15];
      end
      if (acc_wr && is_owner && req_addr == OFS_ADDR) shr_q.addr <= req_wdata;
      if (acc_wr && is_owner && req_addr == OFS_SIZE) shr_q.size <= req_wdata;
      if (commit) lock_valid <= 1'b0;
    end
  end

  // per-CPU status copies
  logic [1:0] regstat_w [N_CPU];
  logic [2:0] qstat_w   [N_CPU];

  for (genvar gi = 0; gi < N_CPU; gi++) begin : g_cpu
    logic             hit;
    logic [1:0]       regstat_q;
    logic             done_q;
    logic [CNT_W-1:0] qcnt_q;

    assign hit = (req_cpu == CPU_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        regstat_q <= 2'b00;
        done_q    <= 1'b0;
        qcnt_q    <= '0;
      end else begin
        if (clash && hit)       regstat_q <= 2'b01;
        else if (commit && hit) regstat_q <= {q_full, 1'b0};

        if (done_valid && done_notify && done_cpu == CPU_W'(gi))
          done_q <= 1'b1;
        else if (acc_wr && hit && req_addr == OFS_QSTAT && req_wdata[2])
          done_q <= 1'b0;

        qcnt_q <= qcnt_q + CNT_W'(push && hit) - CNT_W'(pop && pop_cpu == CPU_W'(gi));
      end
    end

    assign regstat_w[gi]  = regstat_q;
    assign qstat_w[gi]    = {done_q, exec_busy && exec_cpu == CPU_W'(gi), qcnt_q != '0};
    assign done_flags[gi] = done_q;
  end

  // sync and prefetch-flush primitives
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_pend <= 1'b0;
      pf_flush  <= 1'b0;
    end else begin
      pf_flush <= pf_wr;
      if (sync_wr)                                sync_pend <= 1'b1;
      else if (sync_pend && q_empty && !exec_busy) sync_pend <= 1'b0;
    end
  end

  // registered read port
  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    unique case (req_addr)
      OFS_PRIM:    rd_d = {31'd0, sync_pend};
      OFS_REGSTAT: rd_d = is_owner ? {30'd0, q_full, 1'b0} : {30'd0, regstat_w[req_cpu]};
      OFS_QSTAT:   rd_d = {29'd0, qstat_w[req_cpu]};
      default:     rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      rsp_rdata <= acc_rd ? rd_d : '0;
    end
  end
endmodule

// File: rtl/cmq_top.sv
module cmq_top
  import cmq_pkg::*;
#(
  parameter int N_CPU      = 4,
  parameter int Q_DEPTH    = 8,
  parameter int N_SETS     = 64,
  parameter int LINE_BYTES = 32,
  parameter int CPU_W      = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [11:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [CPU_W-1:0] req_cpu,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             line_valid,
  output logic [31:0]      line_addr,
  output logic [1:0]       line_cmd,
  output logic             pf_flush
);
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam int SLOT_W = ENTRY_W + CPU_W;

  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [CNT_W-1:0] fifo_count;
  cmq_entry_t       push_entry, head_entry;
  logic [CPU_W-1:0] push_cpu, head_cpu;
  logic [SLOT_W-1:0] head_slot;
  logic             exec_busy, done_valid, done_notify;
  logic [CPU_W-1:0] exec_cpu, done_cpu;
  logic             lock_valid, sync_pend;
  logic [CPU_W-1:0] lock_owner;
  logic [N_CPU-1:0] done_flags;

  assign head_entry = cmq_entry_t'(head_slot[SLOT_W-1:CPU_W]);
  assign head_cpu   = head_slot[CPU_W-1:0];

  cmq_regs #(.N_CPU(N_CPU), .CPU_W(CPU_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .push(fifo_push), .push_entry(push_entry), .push_cpu(push_cpu),
    .q_full(fifo_full), .q_empty(fifo_empty),
    .pop(fifo_pop), .pop_cpu(head_cpu),
    .exec_busy(exec_busy), .exec_cpu(exec_cpu),
    .done_valid(done_valid), .done_cpu(done_cpu), .done_notify(done_notify),
    .lock_valid(lock_valid), .lock_owner(lock_owner),
    .sync_pend(sync_pend), .done_flags(done_flags), .pf_flush(pf_flush)
  );

  cmq_fifo #(.DATA_W(SLOT_W), .Q_DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(fifo_push), .push_data({push_entry, push_cpu}),
    .pop(fifo_pop), .head_data(head_slot),
    .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
  );

  cmq_exec #(.N_SETS(N_SETS), .LINE_BYTES(LINE_BYTES), .CPU_W(CPU_W)) u_exec (
    .clk(clk), .rst(rst),
    .q_empty(fifo_empty), .head(head_entry), .head_cpu(head_cpu),
    .pop(fifo_pop), .busy(exec_busy), .cur_cpu(exec_cpu),
    .done_valid(done_valid), .done_cpu(done_cpu), .done_notify(done_notify),
    .line_valid(line_valid), .line_addr(line_addr), .line_cmd(line_cmd)
  );
endmodule

// File: rtl/cmq_checker.sv
module cmq_checker
  import cmq_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int Q_DEPTH = 8,
  parameter int CPU_W   = 2,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [11:0]      req_addr,
  input logic [31:0]      req_wdata,
  input logic [CPU_W-1:0] req_cpu,
  input logic             lock_valid,
  input logic [CPU_W-1:0] lock_owner,
  input logic [CNT_W-1:0] fifo_count,
  input logic             fifo_full,
  input logic             fifo_push,
  input logic             fifo_empty,
  input logic             exec_busy,
  input logic             sync_pend,
  input logic             done_valid,
  input logic [CPU_W-1:0] done_cpu,
  input logic             done_notify,
  input logic [N_CPU-1:0] done_flags,
  input logic             pf_flush
);
  assert_lock_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_valid && req_valid && req_write && req_addr == OFS_MODE && req_cpu != lock_owner)
    |=> (lock_valid && lock_owner == $past(lock_owner)));

  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_valid && req_valid && !req_write && req_addr == OFS_REGSTAT && req_cpu == lock_owner)
    |=> !lock_valid);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_count <= CNT_W'(Q_DEPTH)) && !(fifo_push && fifo_full));

  assert_notify_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_notify) |=> done_flags[$past(done_cpu)]);

  assert_sync_drain_R10: assert property (@(posedge clk) disable iff (rst)
    (sync_pend && fifo_empty && !exec_busy &&
     !(req_valid && req_write && req_addr == OFS_PRIM && req_wdata == PRIM_SYNC))
    |=> !sync_pend);

  assert_pf_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == OFS_PRIM && req_wdata == PRIM_PFLUSH)
    |=> pf_flush);
endmodule

bind cmq_top cmq_checker #(
  .N_CPU(N_CPU), .Q_DEPTH(Q_DEPTH), .CPU_W(CPU_W), .CNT_W($clog2(Q_DEPTH + 1))
) u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_cpu(req_cpu),
  .lock_valid(lock_valid), .lock_owner(lock_owner),
  .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_push(fifo_push),
  .fifo_empty(fifo_empty), .exec_busy(exec_busy), .sync_pend(sync_pend),
  .done_valid(done_valid), .done_cpu(done_cpu), .done_notify(done_notify),
  .done_flags(done_flags), .pf_flush(pf_flush)
);

// File: tb/tb_cmq_top.sv
module tb_cmq_top;
  localparam int N_CPU = 4, Q_DEPTH = 4, N_SETS = 8, LINE_BYTES = 16;
  localparam int CPU_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [CPU_W-1:0] req_cpu = '0;
  logic rsp_valid, line_valid, pf_flush;
  logic [31:0] rsp_rdata, line_addr;
  logic [1:0] line_cmd;

  always #10 clk = ~clk;

  cmq_top #(.N_CPU(N_CPU), .Q_DEPTH(Q_DEPTH), .N_SETS(N_SETS), .LINE_BYTES(LINE_BYTES)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .line_valid(line_valid),
    .line_addr(line_addr), .line_cmd(line_cmd), .pf_flush(pf_flush));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [33:0] exp_q [$];

  function automatic logic [31:0] mode(input int scope, input int ntf, input int cmd);
    return (32'(scope) << 17) | (32'(ntf) << 15) | 32'(cmd);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_cpu = CPU_W'(cpu); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_cpu = CPU_W'(cpu); req_addr = a;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  // driver: full registration sequence; on acceptance push the expected lines
  task automatic post(input int cpu, input logic [31:0] m, input logic [31:0] a,
                      input logic [31:0] sz, output logic [31:0] st);
    wr(cpu, 12'h248, m);
    wr(cpu, 12'h24C, a);
    wr(cpu, 12'h250, sz);
    rd(cpu, 12'h25C, st);
    if (st == 0) begin
      if (m[18:17] == 2'd1) begin
        for (int k = 0; k < N_SETS; k++) exp_q.push_back({m[1:0], 32'(k * LINE_BYTES)});
      end else begin
        logic [32:0] first, last;
        first = {1'b0, a & ~32'(LINE_BYTES - 1)};
        last  = {1'b0, a} + {1'b0, sz};
        for (logic [32:0] p = first; p < last; p += 33'(LINE_BYTES))
          exp_q.push_back({m[1:0], p[31:0]});
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare each line strobe with the head of the expected queue (R5 R6 R7)
  always @(negedge clk) begin
    if (!rst && line_valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected line", {30'd0, line_cmd} ^ line_addr, 32'hFFFF_FFFF);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check("R5/R6/R7 line addr", line_addr, e[31:0]);
        check("R5 line cmd", {30'd0, line_cmd}, {30'd0, e[33:32]});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, st;
    int acc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < N_CPU; c++) begin
      rd(c, 12'h25C, d); check("R1 regstat", d, 0);
      rd(c, 12'h260, d); check("R1 qstat", d, 0);
    end
    rd(0, 12'h244, d); check("R1 prim", d, 0);
    check("R1 line idle", {31'd0, line_valid}, 0);

    // R5 unaligned range, R3 accept
    post(0, mode(0, 0, 1), 32'h105, 32'h20, st); check("R3 accept", st, 0);
    drain();

    // R6 whole cache with notify, R8 flags
    post(1, mode(1, 1, 2), 32'hDEAD_BEEF, 32'h7, st); check("R3 accept whole", st, 0);
    drain();
    rd(1, 12'h260, d); check("R8 done set for poster", d, 4);
    rd(0, 12'h260, d); check("R8 other cpu untouched", d, 0);
    wr(1, 12'h260, 32'h4);
    rd(1, 12'h260, d); check("R8 done cleared", d, 0);

    // R2 lock conflict, R12 non-owner status read
    wr(2, 12'h248, mode(0, 0, 1));
    wr(2, 12'h24C, 32'h200);
    wr(3, 12'h248, mode(0, 0, 2));
    rd(3, 12'h25C, d); check("R2 conflict flagged", d, 1);
    wr(3, 12'h24C, 32'h900);
    wr(3, 12'h250, 32'h400);
    rd(3, 12'h25C, d); check("R12 non-owner read", d, 1);
    wr(2, 12'h250, 32'h10);
    rd(2, 12'h25C, st); check("R12 lock kept by owner", st, 0);
    if (st == 0) exp_q.push_back({2'd1, 32'h200});
    post(3, mode(0, 0, 2), 32'h300, 32'h1, st); check("R3 lock released", st, 0);
    drain();

    // R7 ordering across CPUs
    post(0, mode(0, 0, 0), 32'h1000, 32'h40, st); check("R7 post a", st, 0);
    post(1, mode(0, 0, 2), 32'h2000, 32'h10, st); check("R7 post b", st, 0);
    post(2, mode(0, 0, 1), 32'h3008, 32'h10, st); check("R7 post c", st, 0);
    drain();

    // R9 queued / in-progress bits, R10 sync pending
    post(0, mode(0, 0, 1), 32'h8000, 32'h400, st);
    post(1, mode(0, 0, 0), 32'h9000, 32'h10, st);
    rd(0, 12'h260, d); check("R9 cpu0 in progress", d, 2);
    rd(1, 12'h260, d); check("R9 cpu1 queued", d, 1);
    wr(2, 12'h244, 32'h8);
    rd(2, 12'h244, d); check("R10 sync pending", d, 1);
    drain();
    rd(2, 12'h244, d); check("R10 sync drained", d, 0);
    rd(2, 12'h260, d); check("R8 no flag without notify", d, 0);

    // R4 queue full
    acc = 0;
    for (int i = 0; i < 10; i++) begin
      post(0, mode(0, 0, 2), 32'h10000 + 32'(i) * 32'h1000, 32'h400, st);
      if (st != 0) break;
      acc++;
    end
    check("R4 full status", st, 2);
    check("R4 accepted count", 32'(acc), 32'(Q_DEPTH + 1));
    drain();

    // R11 prefetch flush pulse
    wr(0, 12'h244, 32'h9);
    check("R11 pulse high", {31'd0, pf_flush}, 1);
    @(negedge clk);
    check("R11 pulse low", {31'd0, pf_flush}, 0);

    check("R5 scoreboard empty", 32'(exp_q.size()), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule